// File: doc/BRIEF.md
# Hardware Stack Return Sequencer

This block holds the program counter of a small processor core together with an eight-level last-in-first-out hardware stack. It moves words between the stack and data memory or the accumulator. It also steers the program counter on subroutine returns, which come in four kinds: immediate, delayed, conditional and conditional-delayed. A delayed return waits until two instruction words have been fetched before it reloads the program counter. The wait is counted in words, so either two one-word instructions or one two-word instruction fill the gap.

The surrounding core decodes each instruction into a 3-bit operation code and evaluates the condition flag. It also reports in `fetch_words` how many instruction words it fetched in that cycle. The block accepts one operation per clock and never stalls, so it has no back-pressure path. Pop-to-memory data is shown on `wr_data` with the strobe `wr_en` in the same cycle. `wr_data` always shows the current stack top.

Top module: `retseq_top`

## Requirements
- R1: Operation code 1 (pop to memory) raises `wr_en` combinationally in its own cycle while `wr_data` carries the current top. At the next edge the stack moves up one level.
- R2: Operation code 2 (push memory) shifts the stack down one level and places `mem_data` on top at the next edge.
- R3: Operation code 3 (push accumulator) shifts the stack down one level and places bits 15:0 of `acc` on top. The upper accumulator bits have no effect.
- R4: Operation code 4 (return) loads `pc` from the stack top and pops one level at the next edge. `fetch_words` is ignored in that cycle.
- R5: Operation code 5 (delayed return) sets `ret_pending`. The counter starts at 2 and each later cycle subtracts `fetch_words`. At the edge where the fetched words reach the remaining count, `pc` is loaded from the top, the stack pops and `ret_pending` clears. Until then `pc` advances normally.
- R6: Operation code 6 (conditional return) acts as R4 when `cond_ok` is 1. When `cond_ok` is 0, `pc` advances by `fetch_words` and the stack is unchanged.
- R7: Operation code 7 (conditional delayed return) waits the same two words as R5. The pop and the reload happen only if `cond_ok` was 1 when the return was issued. Otherwise `pc` just advances when the wait ends.
- R8: With operation code 0 and no return completing, `pc` advances by `fetch_words` (0, 1 or 2) at each edge.
- R9: A push onto a full stack discards the bottom entry. A pop copies the bottom entry upward, so an emptied stack keeps returning its last bottom value.
- R10: While `ret_pending` is 1, operation codes 2 to 7 raise `illegal_op` combinationally and change neither the stack nor the pending return.
- R11: Synchronous reset sets `pc` to 0, clears `ret_pending` and zeros every stack entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Decoded operation: 0 none, 1 pop to memory, 2 push memory, 3 push accumulator, 4 return, 5 delayed return, 6 conditional return, 7 conditional delayed return |
| cond_ok | input | 1 | Condition result for codes 6 and 7 |
| mem_data | input | 16 | Data-memory word for a push |
| acc | input | 32 | Accumulator |
| fetch_words | input | 2 | Instruction words fetched this cycle (0 to 2) |
| pc | output | 16 | Program counter |
| wr_en | output | 1 | Pop-to-memory write strobe |
| wr_data | output | 16 | Current stack top |
| ret_pending | output | 1 | A delayed return is waiting for its words |
| illegal_op | output | 1 | Current operation was rejected |

## Verification
`wr_en` and `illegal_op` follow the inputs of the same cycle. The bench reads them one nanosecond after it drives a vector, before the next rising edge. `pc`, the stack top on `wr_data` and `ret_pending` change at the first rising edge after a vector is applied, so they are read one nanosecond after that edge. A delayed return completes at the edge of the cycle whose fetched words use up the count. The vector table therefore sets the expected `pc` swap on exactly that vector, including the cases with a zero-word stall and with a single two-word fetch.

// File: rtl/retseq_pkg.sv
package retseq_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_POPM  = 3'd1,
    OP_PSHM  = 3'd2,
    OP_PSHA  = 3'd3,
    OP_RET   = 3'd4,
    OP_RETD  = 3'd5,
    OP_RETC  = 3'd6,
    OP_RETCD = 3'd7
  } seq_op_t;
endpackage

// File: rtl/retseq_stack.sv
module retseq_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top
);
  logic [DW-1:0] lvl [DEPTH];

  assign top = lvl[0];

  always_ff @(posedge clk) begin
    if (rst || push) begin
      lvl[0] <= rst ? '0 : din;
    end else if (pop) begin
      lvl[0] <= lvl[1];
    end
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_lvl
      always_ff @(posedge clk) begin
        if (rst) begin
          lvl[i] <= '0;
        end else if (push) begin
          lvl[i] <= lvl[i-1];
        end else if (pop) begin
          lvl[i] <= (i == DEPTH - 1) ? lvl[i] : lvl[(i == DEPTH - 1) ? i : i + 1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/retseq_delay.sv
module retseq_delay #(
  parameter int FW_W        = 2,
  parameter int DELAY_WORDS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_taken,
  input  logic [FW_W-1:0] fetch_words,
  output logic            pending,
  output logic            fire,
  output logic            fire_taken
);
  localparam int CW   = $clog2(DELAY_WORDS + 1);
  localparam int CMPW = (CW > FW_W) ? CW : FW_W;

  logic [CW-1:0] remain;
  logic          taken_q;
  logic [CMPW-1:0] fw_x, rem_x;

  assign fw_x       = CMPW'(fetch_words);
  assign rem_x      = CMPW'(remain);
  assign fire       = pending && (fw_x >= rem_x);
  assign fire_taken = fire && taken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      remain  <= '0;
      taken_q <= 1'b0;
    end else if (start) begin
      pending <= 1'b1;
      remain  <= CW'(DELAY_WORDS);
      taken_q <= start_taken;
    end else if (fire) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (pending) begin
      remain  <= CW'(rem_x - fw_x);
    end
  end
endmodule

// File: rtl/retseq_top.sv
module retseq_top #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int ACC_W = 32,
  parameter int FW_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_code,
  input  logic             cond_ok,
  input  logic [DW-1:0]    mem_data,
  input  logic [ACC_W-1:0] acc,
  input  logic [FW_W-1:0]  fetch_words,
  output logic [DW-1:0]    pc,
  output logic             wr_en,
  output logic [DW-1:0]    wr_data,
  output logic             ret_pending,
  output logic             illegal_op
);
  import retseq_pkg::*;

  localparam int DELAY_WORDS = 2;

  seq_op_t       op;
  logic          is_push, is_ret, accepted;
  logic          ret_now, dly_start, dly_taken;
  logic          push_en, pop_en;
  logic          fire, fire_taken;
  logic [DW-1:0] push_val, top;

  assign op       = seq_op_t'(op_code);
  assign is_push  = (op == OP_PSHM) || (op == OP_PSHA);
  assign is_ret   = (op == OP_RET) || (op == OP_RETD) ||
                    (op == OP_RETC) || (op == OP_RETCD);

  assign illegal_op = ret_pending && (is_push || is_ret);
  assign accepted   = !illegal_op;

  assign ret_now   = accepted && ((op == OP_RET) || ((op == OP_RETC) && cond_ok));
  assign dly_start = accepted && ((op == OP_RETD) || (op == OP_RETCD));
  assign dly_taken = (op == OP_RETD) || cond_ok;

  assign push_en  = accepted && is_push;
  assign push_val = (op == OP_PSHA) ? acc[DW-1:0] : mem_data;
  assign wr_en    = (op == OP_POPM);
  assign wr_data  = top;
  assign pop_en   = wr_en || ret_now || fire_taken;

  retseq_stack #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk  (clk),
    .rst  (rst),
    .push (push_en),
    .pop  (pop_en),
    .din  (push_val),
    .top  (top)
  );

  retseq_delay #(
    .FW_W        (FW_W),
    .DELAY_WORDS (DELAY_WORDS)
  ) u_delay (
    .clk         (clk),
    .rst         (rst),
    .start       (dly_start),
    .start_taken (dly_taken),
    .fetch_words (fetch_words),
    .pending     (ret_pending),
    .fire        (fire),
    .fire_taken  (fire_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (ret_now || fire_taken) begin
      pc <= top;
    end else begin
      pc <= pc + DW'(fetch_words);
    end
  end
endmodule

// File: rtl/retseq_chk.sv
module retseq_chk #(
  parameter int DW    = 16,
  parameter int ACC_W = 32,
  parameter int FW_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_code,
  input logic             cond_ok,
  input logic [DW-1:0]    mem_data,
  input logic [ACC_W-1:0] acc,
  input logic [FW_W-1:0]  fetch_words,
  input logic [DW-1:0]    pc,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic             ret_pending,
  input logic             illegal_op
);
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (pc == '0 && !ret_pending && wr_data == '0));

  assert_pc_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd0 && !ret_pending) |=> pc == $past(pc) + DW'($past(fetch_words)));

  assert_plain_return_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd4 && !ret_pending) |=> pc == $past(wr_data));

  assert_delay_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd5 && !ret_pending) |=> ret_pending);

  assert_illegal_only_pending_R10: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> ret_pending);

  assert_illegal_keeps_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (illegal_op && fetch_words == '0) |=> ret_pending);

  assert_strobe_pop_only_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> op_code == 3'd1);

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd2 && !ret_pending) |=> wr_data == $past(mem_data));
endmodule

bind retseq_top retseq_chk #(
  .DW    (DW),
  .ACC_W (ACC_W),
  .FW_W  (FW_W)
) u_chk (.*);

// File: tb/tb_retseq_top.sv
module tb_retseq_top;
  localparam int DW = 16;
  localparam int VW = 56;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_code;
  logic          cond_ok;
  logic [DW-1:0] mem_data;
  logic [31:0]   acc;
  logic [1:0]    fetch_words;
  logic [DW-1:0] pc, wr_data;
  logic          wr_en, ret_pending, illegal_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  retseq_top dut (
    .clk (clk), .rst (rst), .op_code (op_code), .cond_ok (cond_ok),
    .mem_data (mem_data), .acc (acc), .fetch_words (fetch_words),
    .pc (pc), .wr_en (wr_en), .wr_data (wr_data),
    .ret_pending (ret_pending), .illegal_op (illegal_op)
  );

  // op, cond, data, fetch, exp pc, exp top, exp pending, exp illegal
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd2, 1'b0, 16'h1111, 2'd1, 16'h0001, 16'h1111, 1'b0, 1'b0},
    {3'd2, 1'b0, 16'h2222, 2'd1, 16'h0002, 16'h2222, 1'b0, 1'b0},
    {3'd3, 1'b0, 16'h3333, 2'd1, 16'h0003, 16'h3333, 1'b0, 1'b0},
    {3'd1, 1'b0, 16'h0000, 2'd1, 16'h0004, 16'h2222, 1'b0, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd2, 16'h0006, 16'h2222, 1'b0, 1'b0},
    {3'd4, 1'b0, 16'h0000, 2'd1, 16'h2222, 16'h1111, 1'b0, 1'b0},
    {3'd2, 1'b0, 16'h0040, 2'd1, 16'h2223, 16'h0040, 1'b0, 1'b0},
    {3'd6, 1'b0, 16'h0000, 2'd1, 16'h2224, 16'h0040, 1'b0, 1'b0},
    {3'd6, 1'b1, 16'h0000, 2'd1, 16'h0040, 16'h1111, 1'b0, 1'b0},
    {3'd2, 1'b0, 16'h0100, 2'd1, 16'h0041, 16'h0100, 1'b0, 1'b0},
    {3'd5, 1'b0, 16'h0000, 2'd1, 16'h0042, 16'h0100, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd1, 16'h0043, 16'h0100, 1'b1, 1'b0},
    {3'd2, 1'b0, 16'h5555, 2'd1, 16'h0100, 16'h1111, 1'b0, 1'b1},
    {3'd2, 1'b0, 16'h0200, 2'd1, 16'h0101, 16'h0200, 1'b0, 1'b0},
    {3'd5, 1'b0, 16'h0000, 2'd1, 16'h0102, 16'h0200, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd2, 16'h0200, 16'h1111, 1'b0, 1'b0},
    {3'd2, 1'b0, 16'h0300, 2'd1, 16'h0201, 16'h0300, 1'b0, 1'b0},
    {3'd7, 1'b0, 16'h0000, 2'd1, 16'h0202, 16'h0300, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd0, 16'h0202, 16'h0300, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd1, 16'h0203, 16'h0300, 1'b1, 1'b0},
    {3'd4, 1'b0, 16'h0000, 2'd1, 16'h0204, 16'h0300, 1'b0, 1'b1},
    {3'd7, 1'b1, 16'h0000, 2'd1, 16'h0205, 16'h0300, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd1, 16'h0206, 16'h0300, 1'b1, 1'b0},
    {3'd0, 1'b0, 16'h0000, 2'd1, 16'h0300, 16'h1111, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1:    return "R1";
      3'd2:    return "R2";
      3'd3:    return "R3";
      3'd4:    return "R4";
      3'd5:    return "R5";
      3'd6:    return "R6";
      3'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic c,
                       input logic [15:0] d, input logic [31:0] a,
                       input logic [1:0] fw);
    op_code = op; cond_ok = c; mem_data = d; acc = a; fetch_words = fw;
  endtask

  task automatic cycle_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(3'd0, 1'b0, '0, '0, 2'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11", "pc", 32'(pc), 32'h0);
    check("R11", "top", 32'(wr_data), 32'h0);
    check("R11", "pending", 32'(ret_pending), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[55:53], v[52], v[51:36], {16'hFFFF, v[51:36]}, v[35:34]);
      #1;
      check("R10", $sformatf("illegal vec%0d", i), 32'(illegal_op), 32'(v[0]));
      cycle_edge();
      check(tag_of(v[55:53]), $sformatf("pc vec%0d", i), 32'(pc), 32'(v[33:18]));
      check(tag_of(v[55:53]), $sformatf("top vec%0d", i), 32'(wr_data), 32'(v[17:2]));
      check(tag_of(v[55:53]), $sformatf("pending vec%0d", i), 32'(ret_pending), 32'(v[1]));
      @(negedge clk);
    end

    // R3: upper accumulator bits have no effect
    drive(3'd3, 1'b0, 16'h0000, 32'hABCD_1234, 2'd0);
    cycle_edge();
    check("R3", "acc low", 32'(wr_data), 32'h1234);
    @(negedge clk);

    // R9: nine pushes onto eight levels, then nine pops
    for (int k = 1; k <= 9; k++) begin
      drive(3'd2, 1'b0, 16'(k), '0, 2'd0);
      @(negedge clk);
    end
    for (int k = 9; k >= 1; k--) begin
      drive(3'd1, 1'b0, '0, '0, 2'd0);
      #1;
      // R1: strobe and data in the cycle of the pop
      check("R1", "wr_en", 32'(wr_en), 32'h1);
      check("R9", $sformatf("pop data k%0d", k), 32'(wr_data), (k >= 2) ? 32'(k) : 32'h2);
      @(negedge clk);
    end
    drive(3'd0, 1'b0, '0, '0, 2'd0);
    #1;
    check("R1", "wr_en idle", 32'(wr_en), 32'h0);
    @(negedge clk);

    // R11: reset while a delayed return waits
    drive(3'd5, 1'b0, '0, '0, 2'd1);
    @(negedge clk);
    check("R5", "pending before reset", 32'(ret_pending), 32'h1);
    rst = 1'b1;
    drive(3'd0, 1'b0, '0, '0, 2'd1);
    cycle_edge();
    check("R11", "pending after reset", 32'(ret_pending), 32'h0);
    check("R11", "pc after reset", 32'(pc), 32'h0);
    check("R11", "top after reset", 32'(wr_data), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule